// File: doc/BRIEF.md
# Dual-Engine Blocked Matrix Multiply Scheduler

This block computes C = alpha·A·B + beta·C in signed fixed-point integer arithmetic using two multiply-accumulate engines that run side by side. The rows of A and C are cut into an upper half and a lower half, and each half belongs to one engine. The columns of B are cut into a left half and a right half, and each half sits in its own bank. An engine reads its A row-block from a private bank and writes its C row-block to a private output bank, so the design uses six banks in all.

The work runs in two stages. In the first stage each engine takes the B half whose index matches its own and fills the matching quarter of its C row-block. After both engines have gone idle, a single swap cycle flips the B bank-select multiplexer. In the second stage each engine fills the remaining quarter from the other engine's B half. A is never copied. Inside an engine, LANES accumulator lanes handle LANES rows of C together. For each output tile, the old C value is fetched once, and it is scaled by beta only after the final k-term has been accumulated.

A simple element port loads matrix entries by row and column and reads results back. That port is decoded into the bank layout using the current dimension inputs.

Top module: `gemm_dual_sched`

## Requirements
- R1: Each element of C becomes alpha·(Σ A(i,p)·B(p,j)) + beta·C_old(i,j), truncated to 48 bits (modulo 2^48). A, B, alpha and beta are 16-bit signed. C is 48-bit signed.
- R2: Any m, n, k from 1 to MAX_DIM gives correct results. This includes odd sizes and sizes that are not multiples of LANES, where the edge tiles are partial.
- R3: Element port. While idle, ld_we writes ld_data at (ld_row, ld_col) into the matrix chosen by ld_mat: 0 = A (row i, column p, low 16 bits), 1 = B (row p, column j, low 16 bits), 2 = C (48 bits). rd_data shows C(rd_row, rd_col) starting one clock after the address is presented. dim_m and dim_n must already hold the run's values when elements are loaded or read.
- R4: After reset, busy and done are 0. An accepted start makes busy 1 from the next cycle. done is a single-cycle pulse with busy still 1 in that cycle, and busy is 0 in the following cycle.
- R5: The swap step lasts exactly one cycle and begins only when both engines are idle. Stage two follows it directly.
- R6: With alpha = 0, every C element becomes beta·C_old.
- R7: With beta = 0, the old C contents have no effect on the result.
- R8: A start pulse while busy is ignored. It produces no second done pulse and leaves the results unchanged.
- R9: ld_we while busy is ignored. The A, B and C banks keep their contents.
- R10: When m = 1 or n = 1, one engine's share or one B half is empty. The run still completes with correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| dim_m | input | 11 | Rows of A and C |
| dim_n | input | 11 | Columns of B and C |
| dim_k | input | 11 | Columns of A, rows of B |
| alpha | input | 16 | Signed scale of the product |
| beta | input | 16 | Signed scale of old C |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ld_we | input | 1 | Element write strobe |
| ld_mat | input | 2 | Matrix select: 0 A, 1 B, 2 C |
| ld_row | input | 11 | Element row |
| ld_col | input | 11 | Element column |
| ld_data | input | 48 | Element value |
| rd_row | input | 11 | C readback row |
| rd_col | input | 11 | C readback column |
| rd_data | output | 48 | C readback value, one cycle after address |

## Verification
If the bank-select multiplexer is wrong after the swap, whole column halves of C come back with the other half's products. This is visible on the first readback after done. A stage barrier that is released too early would let stage two read B while stage one is still writing. The swap-cycle checks would catch this in the cycle it happens, and the results would show damage on rows of the slower engine. An error in the edge masking or the tile walk shows up as wrong values only in the last partial row group or column, so the bench reads back every element of every shape. A done pulse or busy level that is off by a cycle is caught on the exact edge it occurs.

// File: rtl/gemm_pkg.sv
package gemm_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_STAGE1, S_SYNC, S_SWAP, S_STAGE2, S_WRBK, S_DONE
  } stage_e;

  typedef enum logic [1:0] {E_IDLE, E_RUN, E_WAIT, E_WB} eng_e;

  typedef struct packed {
    logic        hi;
    logic [10:0] grp;
    logic [10:0] lane;
  } row_place_t;

  // Final combine: product sum scaled by alpha plus old value scaled by beta.
  function automatic logic signed [47:0] scale_result(
    input logic signed [15:0] alpha,
    input logic signed [47:0] acc,
    input logic signed [15:0] beta,
    input logic signed [47:0] cold
  );
    logic signed [63:0] p;
    logic signed [63:0] q;
    logic signed [63:0] s;
    p = alpha * acc;
    q = beta * cold;
    s = p + q;
    return s[47:0];
  endfunction

  // Which engine half a matrix row belongs to, and its lane group / lane.
  function automatic row_place_t place_row(
    input logic [10:0] r,
    input logic [10:0] split,
    input int          lanes
  );
    row_place_t  p;
    logic [10:0] li;
    p.hi   = (r >= split);
    li     = p.hi ? (r - split) : r;
    p.grp  = 11'(int'(li) / lanes);
    p.lane = 11'(int'(li) % lanes);
    return p;
  endfunction

endpackage

// File: rtl/lane_bank.sv
module lane_bank #(
  parameter int LANES = 4,
  parameter int W     = 16,
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [LANES-1:0]     wmask,
  input  logic [AW-1:0]        waddr,
  input  logic [LANES*W-1:0]   wdata,
  input  logic [AW-1:0]        raddr,
  output logic [LANES*W-1:0]   rdata
);

  logic [LANES*W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (we && wmask[l]) mem[waddr][l*W +: W] <= wdata[l*W +: W];
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/mac_engine.sv
module mac_engine
  import gemm_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int MAX_DIM = 16,
  parameter int AW_AC   = 5,
  parameter int AW_B    = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    go,
  input  logic [10:0]             rows,
  input  logic [10:0]             col_lo,
  input  logic [10:0]             col_hi,
  input  logic [10:0]             depth,
  input  logic signed [15:0]      alpha,
  input  logic signed [15:0]      beta,
  output logic [AW_AC-1:0]        a_raddr,
  input  logic [LANES*16-1:0]     a_rdata,
  output logic [AW_B-1:0]         b_raddr,
  input  logic [15:0]             b_rdata,
  output logic [AW_AC-1:0]        c_raddr,
  input  logic [LANES*48-1:0]     c_rdata,
  output logic                    c_we,
  output logic [LANES-1:0]        c_wmask,
  output logic [AW_AC-1:0]        c_waddr,
  output logic [LANES*48-1:0]     c_wdata,
  output logic                    busy,
  output logic                    fin
);

  localparam int HALF = (MAX_DIM + 1) / 2;

  eng_e        st_q;
  logic [10:0] g_q, kk_q, j_q, j0_q, j1_q, rows_q, k_q, ngrp_q;
  logic        pipe_v, pipe_first;
  logic signed [47:0] acc  [LANES];
  logic signed [47:0] cold [LANES];

  assign a_raddr = AW_AC'(int'(g_q) * MAX_DIM + int'(kk_q));
  assign b_raddr = AW_B'(int'(kk_q) * HALF + int'(j_q) - int'(j0_q));
  assign c_raddr = AW_AC'(int'(g_q) * MAX_DIM + int'(j_q));
  assign c_waddr = c_raddr;
  assign c_we    = (st_q == E_WB);
  assign busy    = (st_q != E_IDLE);

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      c_wdata[l*48 +: 48] = scale_result(alpha, acc[l], beta, cold[l]);
      c_wmask[l]          = (int'(g_q) * LANES + l) < int'(rows_q);
    end
  end

  // MAC lanes: one cycle behind the read issue.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LANES; l++) begin
        acc[l]  <= '0;
        cold[l] <= '0;
      end
    end else if (pipe_v) begin
      for (int l = 0; l < LANES; l++) begin
        acc[l] <= (pipe_first ? 48'sd0 : acc[l])
                  + $signed(a_rdata[l*16 +: 16]) * $signed(b_rdata);
        if (pipe_first) cold[l] <= $signed(c_rdata[l*48 +: 48]);
      end
    end
  end

  // Tile walk: column by column, row group by row group, k terms inside.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= E_IDLE;
      g_q <= '0; kk_q <= '0; j_q <= '0; j0_q <= '0; j1_q <= '0;
      rows_q <= '0; k_q <= '0; ngrp_q <= '0;
      pipe_v <= 1'b0; pipe_first <= 1'b0; fin <= 1'b0;
    end else begin
      fin        <= 1'b0;
      pipe_v     <= 1'b0;
      pipe_first <= 1'b0;
      unique case (st_q)
        E_IDLE: if (go) begin
          rows_q <= rows;
          j0_q   <= col_lo;
          j1_q   <= col_hi;
          j_q    <= col_lo;
          k_q    <= depth;
          g_q    <= '0;
          kk_q   <= '0;
          ngrp_q <= 11'((int'(rows) + LANES - 1) / LANES);
          if (rows == 11'd0 || col_lo >= col_hi) fin <= 1'b1;
          else st_q <= E_RUN;
        end
        E_RUN: begin
          pipe_v     <= 1'b1;
          pipe_first <= (kk_q == 11'd0);
          if (kk_q == k_q - 11'd1) begin
            kk_q <= '0;
            st_q <= E_WAIT;
          end else begin
            kk_q <= kk_q + 11'd1;
          end
        end
        E_WAIT: st_q <= E_WB;
        E_WB: begin
          if (g_q + 11'd1 < ngrp_q) begin
            g_q  <= g_q + 11'd1;
            st_q <= E_RUN;
          end else begin
            g_q <= '0;
            if (j_q + 11'd1 >= j1_q) begin
              st_q <= E_IDLE;
              fin  <= 1'b1;
            end else begin
              j_q  <= j_q + 11'd1;
              st_q <= E_RUN;
            end
          end
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/gemm_dual_sched.sv
module gemm_dual_sched
  import gemm_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int MAX_DIM = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [10:0] dim_m,
  input  logic [10:0] dim_n,
  input  logic [10:0] dim_k,
  input  logic [15:0] alpha,
  input  logic [15:0] beta,
  output logic        busy,
  output logic        done,
  input  logic        ld_we,
  input  logic [1:0]  ld_mat,
  input  logic [10:0] ld_row,
  input  logic [10:0] ld_col,
  input  logic [47:0] ld_data,
  input  logic [10:0] rd_row,
  input  logic [10:0] rd_col,
  output logic [47:0] rd_data
);

  localparam int HALF     = (MAX_DIM + 1) / 2;
  localparam int GROUPS   = (HALF + LANES - 1) / LANES;
  localparam int DEPTH_AC = GROUPS * MAX_DIM;
  localparam int DEPTH_B  = MAX_DIM * HALF;
  localparam int AW_AC    = (DEPTH_AC > 1) ? $clog2(DEPTH_AC) : 1;
  localparam int AW_B     = (DEPTH_B > 1) ? $clog2(DEPTH_B) : 1;

  stage_e      state_q;
  logic        sel_q;
  logic [1:0]  fin_seen_q;
  logic        eng_go;
  logic [1:0]  eng_fin;
  logic [1:0]  eng_busy;
  logic [1:0]  eng_c_we;
  logic        idle;

  logic [AW_AC-1:0]     eng_a_raddr [2];
  logic [AW_B-1:0]      eng_b_raddr [2];
  logic [AW_AC-1:0]     eng_c_raddr [2];
  logic [AW_AC-1:0]     eng_c_waddr [2];
  logic [LANES-1:0]     eng_c_wmask [2];
  logic [LANES*48-1:0]  eng_c_wdata [2];
  logic [LANES*16-1:0]  a_rdata [2];
  logic [15:0]          b_rdata [2];
  logic [LANES*48-1:0]  c_rdata [2];

  logic [10:0] m_half, n_half;
  assign m_half = 11'((12'(dim_m) + 12'd1) >> 1);
  assign n_half = 11'((12'(dim_n) + 12'd1) >> 1);

  assign idle   = (state_q == S_IDLE);
  assign busy   = !idle;
  assign done   = (state_q == S_DONE);
  assign eng_go = (idle && start) || (state_q == S_SWAP);

  // Element port decode into bank coordinates.
  row_place_t        ld_p, rd_p;
  logic              host_ok, ld_b_hi;
  logic [AW_AC-1:0]  ld_ac_addr, rd_ac_addr;
  logic [AW_B-1:0]   ld_b_addr;
  logic [LANES-1:0]  ld_lane_oh;
  logic              rd_hi_q;
  logic [10:0]       rd_lane_q;

  assign ld_p       = place_row(ld_row, m_half, LANES);
  assign rd_p       = place_row(rd_row, m_half, LANES);
  assign host_ok    = ld_we && idle;
  assign ld_ac_addr = AW_AC'(int'(ld_p.grp) * MAX_DIM + int'(ld_col));
  assign rd_ac_addr = AW_AC'(int'(rd_p.grp) * MAX_DIM + int'(rd_col));
  assign ld_lane_oh = LANES'(1) << ld_p.lane;
  assign ld_b_hi    = (ld_col >= n_half);
  assign ld_b_addr  = AW_B'(int'(ld_row) * HALF
                      + int'(ld_b_hi ? (ld_col - n_half) : ld_col));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hi_q   <= 1'b0;
      rd_lane_q <= '0;
    end else begin
      rd_hi_q   <= rd_p.hi;
      rd_lane_q <= rd_p.lane;
    end
  end

  assign rd_data = c_rdata[rd_hi_q][int'(rd_lane_q) * 48 +: 48];

  // Stage sequencer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      sel_q      <= 1'b0;
      fin_seen_q <= '0;
    end else begin
      fin_seen_q <= eng_go ? 2'b00 : (fin_seen_q | eng_fin);
      unique case (state_q)
        S_IDLE:   if (start) begin
                    state_q <= S_STAGE1;
                    sel_q   <= 1'b0;
                  end
        S_STAGE1: if (fin_seen_q == 2'b11) state_q <= S_SYNC;
        S_SYNC:   state_q <= S_SWAP;
        S_SWAP:   begin
                    sel_q   <= 1'b1;
                    state_q <= S_STAGE2;
                  end
        S_STAGE2: if (fin_seen_q == 2'b11) state_q <= S_WRBK;
        S_WRBK:   state_q <= S_DONE;
        S_DONE:   state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  // B halves: bank h is read by engine h before the swap, by the other after.
  for (genvar h = 0; h < 2; h++) begin : g_bhalf
    lane_bank #(.LANES(1), .W(16), .DEPTH(DEPTH_B), .AW(AW_B)) u_bbank (
      .clk   (clk),
      .we    (host_ok && ld_mat == 2'd1 && ld_b_hi == 1'(h)),
      .wmask (1'b1),
      .waddr (ld_b_addr),
      .wdata (ld_data[15:0]),
      .raddr (eng_b_raddr[1'(h) ^ sel_q]),
      .rdata (b_rdata[h])
    );
  end

  for (genvar e = 0; e < 2; e++) begin : g_eng
    logic        half;
    logic [10:0] rows_e, j_lo, j_hi;
    logic        host_c;

    assign half   = 1'(e) ^ (state_q == S_SWAP);
    assign rows_e = (e == 0) ? m_half : (dim_m - m_half);
    assign j_lo   = half ? n_half : 11'd0;
    assign j_hi   = half ? dim_n : n_half;
    assign host_c = host_ok && ld_mat == 2'd2 && ld_p.hi == 1'(e);

    lane_bank #(.LANES(LANES), .W(16), .DEPTH(DEPTH_AC), .AW(AW_AC)) u_abank (
      .clk   (clk),
      .we    (host_ok && ld_mat == 2'd0 && ld_p.hi == 1'(e)),
      .wmask (ld_lane_oh),
      .waddr (ld_ac_addr),
      .wdata ({LANES{ld_data[15:0]}}),
      .raddr (eng_a_raddr[e]),
      .rdata (a_rdata[e])
    );

    lane_bank #(.LANES(LANES), .W(48), .DEPTH(DEPTH_AC), .AW(AW_AC)) u_cbank (
      .clk   (clk),
      .we    (idle ? host_c : eng_c_we[e]),
      .wmask (idle ? ld_lane_oh : eng_c_wmask[e]),
      .waddr (idle ? ld_ac_addr : eng_c_waddr[e]),
      .wdata (idle ? {LANES{ld_data}} : eng_c_wdata[e]),
      .raddr (idle ? rd_ac_addr : eng_c_raddr[e]),
      .rdata (c_rdata[e])
    );

    mac_engine #(.LANES(LANES), .MAX_DIM(MAX_DIM), .AW_AC(AW_AC), .AW_B(AW_B)) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (eng_go),
      .rows    (rows_e),
      .col_lo  (j_lo),
      .col_hi  (j_hi),
      .depth   (dim_k),
      .alpha   (alpha),
      .beta    (beta),
      .a_raddr (eng_a_raddr[e]),
      .a_rdata (a_rdata[e]),
      .b_raddr (eng_b_raddr[e]),
      .b_rdata (b_rdata[1'(e) ^ sel_q]),
      .c_raddr (eng_c_raddr[e]),
      .c_rdata (c_rdata[e]),
      .c_we    (eng_c_we[e]),
      .c_wmask (eng_c_wmask[e]),
      .c_waddr (eng_c_waddr[e]),
      .c_wdata (eng_c_wdata[e]),
      .busy    (eng_busy[e]),
      .fin     (eng_fin[e])
    );
  end

endmodule

// File: rtl/gemm_dual_sched_chk.sv
module gemm_dual_sched_chk
  import gemm_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input stage_e     state,
  input logic       busy,
  input logic       done,
  input logic       start,
  input logic [1:0] eng_busy,
  input logic [1:0] eng_c_we,
  input logic       b_sel
);

  // R4: done lasts one cycle and busy drops right after it
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R4: an accepted start raises busy on the next cycle
  a_r4_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  // R5: the swap takes one cycle and leads straight into stage two
  a_r5_swap_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SWAP) |=> (state == S_STAGE2 && b_sel));

  // R5: both engines must be idle when the B ownership flips
  a_r5_barrier: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SWAP) |-> (eng_busy == 2'b00));

  // R5: stage one always reads B with the unswapped mapping
  a_r5_stage1_unswapped: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STAGE1) |-> !b_sel);

  // R9: engine result writes occur only inside a compute stage
  a_r9_writes_in_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (|eng_c_we) |-> (state == S_STAGE1 || state == S_STAGE2));

endmodule

bind gemm_dual_sched gemm_dual_sched_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .state    (state_q),
  .busy     (busy),
  .done     (done),
  .start    (start),
  .eng_busy (eng_busy),
  .eng_c_we (eng_c_we),
  .b_sel    (sel_q)
);

// File: tb/gemm_dual_sched_tb.sv
module gemm_dual_sched_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 4;
  localparam int MAXD       = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [10:0] dim_m = 11'd1, dim_n = 11'd1, dim_k = 11'd1;
  logic [15:0] alpha = '0, beta = '0;
  logic        busy, done;
  logic        ld_we = 1'b0;
  logic [1:0]  ld_mat = '0;
  logic [10:0] ld_row = '0, ld_col = '0;
  logic [47:0] ld_data = '0;
  logic [10:0] rd_row = '0, rd_col = '0;
  logic [47:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  longint ra [MAXD][MAXD];
  longint rb [MAXD][MAXD];
  logic [47:0] rc [MAXD][MAXD];

  always #(CLK_PERIOD/2) clk = ~clk;

  gemm_dual_sched #(.LANES(LANES), .MAX_DIM(MAXD)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dim_m(dim_m), .dim_n(dim_n), .dim_k(dim_k),
    .alpha(alpha), .beta(beta), .busy(busy), .done(done),
    .ld_we(ld_we), .ld_mat(ld_mat), .ld_row(ld_row), .ld_col(ld_col),
    .ld_data(ld_data), .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sx16(input int v);
    longint t;
    t = longint'(v) & 64'hFFFF;
    return (t >= 32768) ? t - 65536 : t;
  endfunction

  function automatic longint sx48(input logic [47:0] v);
    return v[47] ? (longint'(v) - (longint'(1) <<< 48)) : longint'(v);
  endfunction

  task automatic put(input logic [1:0] mat, input int r, input int c, input logic [47:0] v);
    @(negedge clk);
    ld_we = 1'b1; ld_mat = mat; ld_row = 11'(r); ld_col = 11'(c); ld_data = v;
  endtask

  task automatic get(input int r, input int c, output logic [47:0] v);
    @(negedge clk);
    rd_row = 11'(r); rd_col = 11'(c);
    @(negedge clk);
    v = rd_data;
  endtask

  // Fill A, B and old C with fresh values and load them through the port (R3).
  task automatic load_all(input int m, input int n, input int k);
    for (int i = 0; i < m; i++)
      for (int p = 0; p < k; p++) begin
        ra[i][p] = sx16(int'($urandom));
        put(2'd0, i, p, 48'(ra[i][p]));
      end
    for (int p = 0; p < k; p++)
      for (int j = 0; j < n; j++) begin
        rb[p][j] = sx16(int'($urandom));
        put(2'd1, p, j, 48'(rb[p][j]));
      end
    for (int i = 0; i < m; i++)
      for (int j = 0; j < n; j++) begin
        rc[i][j] = {16'($urandom), 32'($urandom)};
        put(2'd2, i, j, rc[i][j]);
      end
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  // Start, watch busy/done timing (R4), optionally poke start and ld_we mid-run (R8, R9).
  task automatic run_op(input string req, input bit poke);
    int cyc;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, {"R4 busy after start ", req}, longint'(busy), 1);
    cyc = 0;
    while (done !== 1'b1 && cyc < 20000) begin
      if (poke && cyc == 5) begin
        start = 1'b1; ld_we = 1'b1; ld_mat = 2'd0; ld_row = 11'd0; ld_col = 11'd0;
        ld_data = 48'h1234;
      end else begin
        start = 1'b0; ld_we = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; ld_we = 1'b0;
    chk(done === 1'b1 && busy === 1'b1, {"R4 done pulse ", req}, longint'(done), 1);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, {"R4 done single cycle ", req}, longint'(done), 0);
    if (poke) begin
      bit extra = 1'b0;
      for (int t = 0; t < 12; t++) begin
        if (done === 1'b1 || busy === 1'b1) extra = 1'b1;
        @(negedge clk);
      end
      chk(!extra, "R8 start while busy gave no second run", longint'(extra), 0);
    end
  endtask

  task automatic scenario(input string req, input int m, input int n, input int k,
                          input int al, input int be, input bit reload, input bit poke);
    logic [47:0] expv [MAXD][MAXD];
    logic [47:0] got;
    longint acc, tot;
    dim_m = 11'(m); dim_n = 11'(n); dim_k = 11'(k);
    alpha = 16'(al); beta = 16'(be);
    if (reload) load_all(m, n, k);
    for (int i = 0; i < m; i++)
      for (int j = 0; j < n; j++) begin
        acc = 0;
        for (int p = 0; p < k; p++) acc += ra[i][p] * rb[p][j];
        tot = sx16(al) * acc + sx16(be) * sx48(rc[i][j]);
        expv[i][j] = tot[47:0];
      end
    run_op(req, poke);
    for (int i = 0; i < m; i++)
      for (int j = 0; j < n; j++) begin
        get(i, j, got);
        chk(got === expv[i][j], req, sx48(got), sx48(expv[i][j]));
        rc[i][j] = expv[i][j];
      end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R4 watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R4 reset state", longint'({busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R4 idle after reset", longint'({busy, done}), 0);

    scenario("R1 R2 R10 unit 1x1x1",          1,  1,  1,   3,  -2, 1'b1, 1'b0);
    scenario("R1 R3 square 8x8x8",            8,  8,  8,   1,   1, 1'b1, 1'b0);
    scenario("R2 nonsquare 5x7x3",            5,  7,  3,  -7,   5, 1'b1, 1'b0);
    scenario("R2 R10 tall 9x1x6",             9,  1,  6,   4,  -3, 1'b1, 1'b0);
    scenario("R2 R10 wide 1x11x2",            1, 11,  2,  -1,   2, 1'b1, 1'b0);
    scenario("R6 alpha zero 6x5x4",           6,  5,  4,   0,   9, 1'b1, 1'b0);
    scenario("R7 beta zero 7x6x5",            7,  6,  5,  11,   0, 1'b1, 1'b0);
    scenario("R1 R8 max with truncation",    16, 16, 16, -32768, 32767, 1'b1, 1'b1);
    scenario("R9 rerun keeps original A",    16, 16, 16,   1,   0, 1'b0, 1'b0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule